// File: doc/BRIEF.md
# Two-Level Masked Interrupt Status Controller

This block gathers single-cycle event pulses from a serial channel and reports them to software through two levels of status. A primary status register holds three event flags and an extended status register holds five more. Above them, a summary register has one bit per lower register. That bit is set while the lower register shows at least one visible pending flag. One level-sensitive interrupt output is driven from the summary.

Each event has its own mask bit. A masked event is still captured in an internal pending latch, but the status registers, the summary and the interrupt output do not show it. When software clears the mask bit, the latched event becomes visible and raises the interrupt. Reading a status register returns its visible flags and clears only those flags. Software uses the block through a small register port with combinational read data.

Top module: `hier_irq_ctrl`

## Requirements
- R1: After reset, both pending sets are empty, the summary reads 0, `irq` is low, the primary mask reads all ones (0x07) and the extended mask reads all ones (0x1F).
- R2: A one-cycle pulse on `evt_pri[i]` or `evt_ext[i]` whose mask bit is 0 sets bit i of the primary status register (address 1) or the extended status register (address 2). In the primary register, bit 0 is the receive event, bit 1 the transmit event and bit 2 the special-condition event.
- R3: Summary register (address 0) bit 0 is 1 exactly when the primary status has a visible flag, and bit 1 is 1 exactly when the extended status has one. All other bits read 0.
- R4: `irq` is high exactly when the summary is nonzero, and stays high until all visible flags are cleared.
- R5: An event whose mask bit is 1 does not appear in its status register, in the summary or on `irq`, but it is still latched.
- R6: Clearing the mask bit of a latched event (mask registers at addresses 3 and 4, bit i masks event i) makes the event visible in status, summary and `irq` on the next cycle.
- R7: A read of a status register clears only the flags it returned. Masked pending events stay latched.
- R8: An event pulse that arrives in the same cycle as a clearing read of its register stays pending afterwards.
- R9: Writes to addresses 0, 1 and 2 have no effect. Only the mask registers are writable.
- R10: Reading the summary register does not clear anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears status flags at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the same cycle as `reg_rd` |
| evt_pri | input | 3 | Primary event pulses (receive, transmit, special) |
| evt_ext | input | 5 | Extended event pulses |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default widths: three primary flags, five extended flags and an 8-bit data path. With these widths, every event bit and every mask bit can be reached from a short table of mixed mask and event patterns. The same widths also allow directed cases for the mask-reveal path, a pulse that collides with a clearing read, and writes aimed at read-only addresses.

// File: rtl/hier_irq_pkg.sv
package hier_irq_pkg;
  typedef enum logic [2:0] {
    ADDR_SUM  = 3'd0,
    ADDR_PRI  = 3'd1,
    ADDR_EXT  = 3'd2,
    ADDR_PMSK = 3'd3,
    ADDR_EMSK = 3'd4
  } reg_addr_e;

  localparam int SUM_PRI_BIT = 0;
  localparam int SUM_EXT_BIT = 1;
  localparam int SUM_W       = 2;
endpackage

// File: rtl/hier_irq_bank.sv
module hier_irq_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic [W-1:0] vis,
  output logic         any_vis
);
  function automatic logic [W-1:0] visible_of(logic [W-1:0] p, logic [W-1:0] m);
    return p & ~m;
  endfunction

  function automatic logic [W-1:0] next_pend(logic [W-1:0] p, logic [W-1:0] m,
                                             logic c, logic [W-1:0] e);
    logic [W-1:0] drop;
    drop = c ? visible_of(p, m) : '0;
    return (p & ~drop) | e;
  endfunction

  assign vis     = visible_of(pend, mask);
  assign any_vis = |vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '1;
    end else begin
      pend <= next_pend(pend, mask, clr, ev);
      if (mask_we) mask <= mask_wd;
    end
  end
endmodule

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl
  import hier_irq_pkg::*;
#(
  parameter int PRI_W  = 3,
  parameter int EXT_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [PRI_W-1:0]  evt_pri,
  input  logic [EXT_W-1:0]  evt_ext,
  output logic              irq
);
  logic [PRI_W-1:0] pri_pend, pri_mask, pri_vis;
  logic [EXT_W-1:0] ext_pend, ext_mask, ext_vis;
  logic             pri_any, ext_any;
  logic             pri_clr, ext_clr, pmsk_we, emsk_we;
  logic [SUM_W-1:0] sum_reg;

  assign pri_clr = reg_rd && (reg_addr == ADDR_PRI);
  assign ext_clr = reg_rd && (reg_addr == ADDR_EXT);
  assign pmsk_we = reg_wr && (reg_addr == ADDR_PMSK);
  assign emsk_we = reg_wr && (reg_addr == ADDR_EMSK);

  hier_irq_bank #(.W(PRI_W)) u_pri (
    .clk(clk), .rst_n(rst_n), .ev(evt_pri), .clr(pri_clr),
    .mask_we(pmsk_we), .mask_wd(reg_wdata[PRI_W-1:0]),
    .pend(pri_pend), .mask(pri_mask), .vis(pri_vis), .any_vis(pri_any)
  );

  hier_irq_bank #(.W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .ev(evt_ext), .clr(ext_clr),
    .mask_we(emsk_we), .mask_wd(reg_wdata[EXT_W-1:0]),
    .pend(ext_pend), .mask(ext_mask), .vis(ext_vis), .any_vis(ext_any)
  );

  always_comb begin
    sum_reg = '0;
    sum_reg[SUM_PRI_BIT] = pri_any;
    sum_reg[SUM_EXT_BIT] = ext_any;
  end

  assign irq = |sum_reg;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_SUM:  reg_rdata = DATA_W'(sum_reg);
      ADDR_PRI:  reg_rdata = DATA_W'(pri_vis);
      ADDR_EXT:  reg_rdata = DATA_W'(ext_vis);
      ADDR_PMSK: reg_rdata = DATA_W'(pri_mask);
      ADDR_EMSK: reg_rdata = DATA_W'(ext_mask);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hier_irq_ctrl_chk.sv
module hier_irq_ctrl_chk #(
  parameter int PRI_W = 3,
  parameter int EXT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [PRI_W-1:0] evt_pri,
  input logic [PRI_W-1:0] pri_pend,
  input logic [PRI_W-1:0] pri_mask,
  input logic [PRI_W-1:0] pri_vis,
  input logic [EXT_W-1:0] ext_pend,
  input logic [EXT_W-1:0] ext_mask,
  input logic [EXT_W-1:0] ext_vis,
  input logic             pri_clr,
  input logic             pmsk_we,
  input logic [1:0]       sum_reg
);
  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((|(pri_pend & ~pri_mask)) || (|(ext_pend & ~ext_mask))));

  // R2
  event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pri) |=> ((pri_pend & $past(evt_pri)) == $past(evt_pri)));

  // R5
  masked_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pri_vis & pri_mask) == '0) && ((ext_vis & ext_mask) == '0));

  // R7
  masked_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_clr && !pmsk_we) |=>
      ((pri_pend & $past(pri_pend & pri_mask)) == $past(pri_pend & pri_mask)));

  // R3
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_reg[0] == (pri_vis != '0)) && (sum_reg[1] == (ext_vis != '0)));
endmodule

bind hier_irq_ctrl hier_irq_ctrl_chk #(.PRI_W(PRI_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .evt_pri(evt_pri),
  .pri_pend(pri_pend), .pri_mask(pri_mask), .pri_vis(pri_vis),
  .ext_pend(ext_pend), .ext_mask(ext_mask), .ext_vis(ext_vis),
  .pri_clr(pri_clr), .pmsk_we(pmsk_we), .sum_reg(sum_reg)
);

// File: tb/tb_hier_irq_ctrl.sv
module tb_hier_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // each vector: {event_pri[2:0], event_ext[4:0], mask_pri[2:0], mask_ext[4:0]}
  localparam logic [15:0] VECS [NVEC] = '{
    {3'b001, 5'b00000, 3'b000, 5'b00000},
    {3'b000, 5'b10010, 3'b111, 5'b00000},
    {3'b111, 5'b11111, 3'b010, 5'b01100},
    {3'b110, 5'b00001, 3'b110, 5'b00001},
    {3'b000, 5'b00000, 3'b000, 5'b00000},
    {3'b101, 5'b01010, 3'b000, 5'b11111}
  };

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [2:0] evt_pri = 0;
  logic [4:0] evt_ext = 0;
  logic       irq;
  int checks = 0, errors = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hier_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pri(evt_pri), .evt_ext(evt_ext), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse(logic [2:0] p, logic [4:0] e);
    @(negedge clk); evt_pri = p; evt_ext = e;
    @(negedge clk); evt_pri = 0; evt_ext = 0;
  endtask

  function automatic logic [7:0] sum_of(logic [2:0] p, logic [4:0] e);
    return {6'd0, (e != 0), (p != 0)};
  endfunction

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, d); chk("R1 summary", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(3, d); chk("R1 pri mask", d, 8'h07);
    rd(4, d); chk("R1 ext mask", d, 8'h1F);

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] ep, mp; logic [4:0] ee, me;
      {ep, ee, mp, me} = VECS[i];
      wr(3, {5'd0, mp}); wr(4, {3'd0, me});
      pulse(ep, ee);
      rd(0, d); chk("R3 summary", d, sum_of(ep & ~mp, ee & ~me));
      #1 chk("R4 irq", {7'd0, irq}, {7'd0, |sum_of(ep & ~mp, ee & ~me)});
      rd(1, d); chk("R2/R5 pri status", d, {5'd0, ep & ~mp});
      rd(2, d); chk("R2/R5 ext status", d, {3'd0, ee & ~me});
      #1 chk("R7 irq after clear", {7'd0, irq}, 8'h00);
      wr(3, 0); wr(4, 0);
      #1 chk("R6 irq reveal", {7'd0, irq}, {7'd0, |sum_of(ep & mp, ee & me)});
      rd(1, d); chk("R6 pri reveal", d, {5'd0, ep & mp});
      rd(2, d); chk("R6 ext reveal", d, {3'd0, ee & me});
      #1 chk("R4 irq idle", {7'd0, irq}, 8'h00);
    end

    // R10 summary read does not clear; R9 writes to status ignored
    pulse(3'b100, 5'b00000);
    rd(0, d); chk("R10 summary first", d, 8'h01);
    rd(0, d); chk("R10 summary again", d, 8'h01);
    wr(1, 8'h00); wr(0, 8'h00); wr(2, 8'hFF);
    rd(1, d); chk("R9 pri after write", d, 8'h04);
    rd(2, d); chk("R9 ext after write", d, 8'h00);

    // R8 event together with clearing read
    pulse(3'b001, 5'b00000);
    @(negedge clk); reg_addr = 1; reg_rd = 1; evt_pri = 3'b001; #1 d = reg_rdata;
    chk("R8 read during event", d, 8'h01);
    @(negedge clk); reg_rd = 0; evt_pri = 0;
    rd(1, d); chk("R8 kept", d, 8'h01);

    // R7 clear only visible, masked survives
    wr(3, 8'h02);
    pulse(3'b011, 5'b00000);
    rd(1, d); chk("R7 visible part", d, 8'h01);
    rd(1, d); chk("R7 cleared", d, 8'h00);
    wr(3, 8'h00);
    rd(1, d); chk("R7 masked kept", d, 8'h02);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule